// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Threshold Requests

This block sits between a register bus and a serial audio shifter. It buffers outgoing sample words in one FIFO and incoming sample words in another. Software writes playback words into the transmit FIFO through a data register. The shifter pulls those words out one at a time. In the other direction, the shifter pushes captured words into the receive FIFO and software drains them through a second data register. Simple read and write strobes stand in for the bus. A read returns its data in the same cycle, and the side effect of the read takes place at the next clock edge.

Each FIFO has an occupancy count and a request flag that compares that count against a programmable 5-bit threshold. Each FIFO can be held empty on its own while the other one keeps running. A self-clearing soft reset returns the whole block to its reset state. Four error flags record overflow and underflow on either side. The error flags and the request flags are sticky, and writing 0 to a flag clears it. Three interrupt outputs combine the flags with their enable bits.

Word addresses: 0 error enables, 1 error status, 2 FIFO control, 3 FIFO status, 4 thresholds, 5 transmit data (write), 6 receive data (read).

Top module: `pcm_fifo_pair`

## Requirements
- R1: After reset every register reads 0. The exceptions are the idle bit (bit 25 of address 1), which reads 1, and the transmit request flag, which sets one cycle later because the empty FIFO has more free space than the reset threshold of 0. All outputs are 0 after reset.
- R2: Each FIFO holds 32 words and delivers them in the order they were written. The transmit count reads at bits 29:24 of address 3 and the receive count at bits 13:8. The head of the transmit FIFO is shown on tx_word.
- R3: Bus-side errors:
  - A write to a full transmit FIFO is dropped and sets bit 28 (transmit overflow) of address 1.
  - A read of address 6 while the receive FIFO is empty returns 0 and sets bit 27 (receive underflow).
- R4: Shifter-side errors:
  - A pull from an empty transmit FIFO presents 0 and sets bit 29 (transmit underflow) of address 1.
  - A push into a full receive FIFO is dropped and sets bit 26 (receive overflow).
- R5: The error flags are sticky. Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. A new event in the same cycle as a clear wins over the clear.
- R6: The transmit request flag is bit 16 of address 3. It sets one cycle after the free space (32 minus the count) exceeds the transmit threshold, which is bits 12:8 of address 4. It stays set until a 0 is written to it while the condition is false.
- R7: The receive request flag is bit 0 of address 3. It sets one cycle after the receive count exceeds the receive threshold, which is bits 4:0 of address 4. It clears the same way as the transmit request flag.
- R8: The interrupt outputs combine flags with enables:
  - tx_req_irq is the transmit request flag gated by bit 3 of address 2.
  - rx_req_irq is the receive request flag gated by bit 2 of address 2.
  - err_irq is set when any error flag in address 1 has its enable set at the same bit position of address 0. Only bits 29:26 of address 0 are writable.
- R9: While bit 1 (transmit) or bit 0 (receive) of address 2 is 1:
  - that FIFO stays empty;
  - its request flag is held at 0;
  - pushes and pops on it neither move data nor raise error flags;
  - the other FIFO works normally.
- R10: Writing 1 to bit 16 of address 2 makes that bit read 1 for exactly one cycle. All registers, flags and FIFOs then return to their reset values.
- R11: Bit 25 of address 1 reads 1 exactly when both FIFOs are empty. The aclk_en output follows bit 31 of address 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive FIFO at address 6) |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| tx_pull | input | 1 | Shifter takes the transmit head word |
| tx_word | output | 32 | Transmit head word, 0 when the FIFO is empty |
| rx_push | input | 1 | Shifter delivers a received word |
| rx_word | input | 32 | Received word |
| tx_req_irq | output | 1 | Transmit service request interrupt |
| rx_req_irq | output | 1 | Receive service request interrupt |
| err_irq | output | 1 | Enabled error interrupt |
| aclk_en | output | 1 | Audio clock enable from the control register |

## Verification
The hardest states to reach are the ones where the sticky behaviour shows: a request flag that stays set after its condition has gone away, and an error flag that survives a write of ones.

The stimulus reaches them in a fixed order:
- It sets the transmit threshold to 31, so that one stored word makes the transmit condition false while the flag is still set.
- It fills each FIFO past 32 words to force the overflow paths.
- It pulls from the transmit FIFO after it has been drained, to force the underflow path.

The bench also holds the transmit FIFO in reset while it pushes received data. This shows that the receive FIFO keeps working and that no error flag is raised. The single cycle in which the soft reset bit reads 1 is sampled with a read issued directly after the write.

// File: rtl/pcm_fifo_pkg.sv
package pcm_fifo_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_ERREN = 3'd0;
  localparam logic [ADDR_W-1:0] A_ERRST = 3'd1;
  localparam logic [ADDR_W-1:0] A_FCTL  = 3'd2;
  localparam logic [ADDR_W-1:0] A_FSTAT = 3'd3;
  localparam logic [ADDR_W-1:0] A_THR   = 3'd4;
  localparam logic [ADDR_W-1:0] A_TXD   = 3'd5;
  localparam logic [ADDR_W-1:0] A_RXD   = 3'd6;

  // Bit positions decoded by software
  localparam int B_ERR_LO = 26;  // 29 tx udf, 28 tx ovf, 27 rx udf, 26 rx ovf
  localparam int B_IDLE   = 25;
  localparam int B_ACLK   = 31;
  localparam int B_SRST   = 16;
  localparam int B_TIE    = 3;
  localparam int B_RIE    = 2;
  localparam int B_TFRST  = 1;
  localparam int B_RFRST  = 0;
  localparam int B_TXCNT  = 24;
  localparam int B_TREQ   = 16;
  localparam int B_RXCNT  = 8;
  localparam int B_RREQ   = 0;
  localparam int B_TXTHR  = 8;
  localparam int B_RXTHR  = 0;

  // Transmit request: free space strictly above threshold
  function automatic logic space_over(input int unsigned fill,
                                      input int unsigned depth,
                                      input int unsigned thr);
    if (fill > depth) return 1'b0;
    return (depth - fill) > thr;
  endfunction

  // Receive request: occupancy strictly above threshold
  function automatic logic fill_over(input int unsigned fill,
                                     input int unsigned thr);
    return fill > thr;
  endfunction
endpackage

// File: rtl/pcm_fifo_store.sv
module pcm_fifo_store #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count,
  output logic             push_drop,
  output logic             pop_miss
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic full, empty, do_push, do_pop;

  assign full      = (count == CW'(DEPTH));
  assign empty     = (count == '0);
  assign do_push   = push & ~clr & ~full;
  assign do_pop    = pop  & ~clr & ~empty;
  assign push_drop = push & ~clr & full;
  assign pop_miss  = pop  & ~clr & empty;
  assign dout      = empty ? '0 : mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_push_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full && !pop && !clr) |=> count == $past(count) + 1'b1);
  assert_drop_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_drop && !pop) |=> count == $past(count));
  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0);
endmodule

// File: rtl/pcm_sticky_bits.sv
module pcm_sticky_bits #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wipe,
  input  logic [N-1:0] hold,
  input  logic [N-1:0] set,
  input  logic [N-1:0] wclr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 q[i] <= 1'b0;
      else if (wipe || hold[i])   q[i] <= 1'b0;
      else if (set[i])            q[i] <= 1'b1;
      else if (wclr[i])           q[i] <= 1'b0;
    end

    assert_zero_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wclr[i] && !set[i]) |=> !q[i]);
    assert_hold_forces_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hold[i] |=> !q[i]);
  end
endmodule

// File: rtl/pcm_fifo_pair.sv
module pcm_fifo_pair
  import pcm_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int WIDTH = 32,
  parameter int THR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              tx_pull,
  output logic [WIDTH-1:0]  tx_word,
  input  logic              rx_push,
  input  logic [WIDTH-1:0]  rx_word,
  output logic              tx_req_irq,
  output logic              rx_req_irq,
  output logic              err_irq,
  output logic              aclk_en
);
  localparam int CW = $clog2(DEPTH) + 1;

  // Bus decode events
  logic wr_erren, wr_errst, wr_fctl, wr_fstat, wr_thr, wr_txd, rd_rxd;
  assign wr_erren = bus_wr && bus_addr == A_ERREN;
  assign wr_errst = bus_wr && bus_addr == A_ERRST;
  assign wr_fctl  = bus_wr && bus_addr == A_FCTL;
  assign wr_fstat = bus_wr && bus_addr == A_FSTAT;
  assign wr_thr   = bus_wr && bus_addr == A_THR;
  assign wr_txd   = bus_wr && bus_addr == A_TXD;
  assign rd_rxd   = bus_rd && bus_addr == A_RXD;

  // Control state
  logic             srst_q;
  logic [3:0]       err_en;
  logic             aclk_q, tie_q, rie_q, tfrst_q, rfrst_q;
  logic [THR_W-1:0] thr_tx, thr_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) srst_q <= 1'b0;
    else        srst_q <= !srst_q && wr_fctl && bus_wdata[B_SRST];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_en  <= '0;
      aclk_q  <= 1'b0;
      tie_q   <= 1'b0;
      rie_q   <= 1'b0;
      tfrst_q <= 1'b0;
      rfrst_q <= 1'b0;
      thr_tx  <= '0;
      thr_rx  <= '0;
    end else if (srst_q) begin
      err_en  <= '0;
      aclk_q  <= 1'b0;
      tie_q   <= 1'b0;
      rie_q   <= 1'b0;
      tfrst_q <= 1'b0;
      rfrst_q <= 1'b0;
      thr_tx  <= '0;
      thr_rx  <= '0;
    end else begin
      if (wr_erren) err_en <= bus_wdata[B_ERR_LO +: 4];
      if (wr_fctl) begin
        aclk_q  <= bus_wdata[B_ACLK];
        tie_q   <= bus_wdata[B_TIE];
        rie_q   <= bus_wdata[B_RIE];
        tfrst_q <= bus_wdata[B_TFRST];
        rfrst_q <= bus_wdata[B_RFRST];
      end
      if (wr_thr) begin
        thr_tx <= bus_wdata[B_TXTHR +: THR_W];
        thr_rx <= bus_wdata[B_RXTHR +: THR_W];
      end
    end
  end

  // FIFOs
  logic             tx_clr, rx_clr;
  logic [CW-1:0]    tx_cnt, rx_cnt;
  logic [WIDTH-1:0] rx_head;
  logic             ev_tx_ovf, ev_tx_udf, ev_rx_ovf, ev_rx_udf;

  assign tx_clr = tfrst_q | srst_q;
  assign rx_clr = rfrst_q | srst_q;

  pcm_fifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr),
    .push(wr_txd), .din(bus_wdata[WIDTH-1:0]), .pop(tx_pull),
    .dout(tx_word), .count(tx_cnt),
    .push_drop(ev_tx_ovf), .pop_miss(ev_tx_udf)
  );

  pcm_fifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr),
    .push(rx_push), .din(rx_word), .pop(rd_rxd),
    .dout(rx_head), .count(rx_cnt),
    .push_drop(ev_rx_ovf), .pop_miss(ev_rx_udf)
  );

  // Error flags: [3] tx udf, [2] tx ovf, [1] rx udf, [0] rx ovf
  logic [3:0] err_q, err_set, err_wclr;
  assign err_set  = {ev_tx_udf, ev_tx_ovf, ev_rx_udf, ev_rx_ovf};
  assign err_wclr = wr_errst ? ~bus_wdata[B_ERR_LO +: 4] : 4'b0;

  pcm_sticky_bits #(.N(4)) u_err_flags (
    .clk(clk), .rst_n(rst_n), .wipe(srst_q), .hold(4'b0),
    .set(err_set), .wclr(err_wclr), .q(err_q)
  );

  // Request flags: [1] transmit, [0] receive
  logic       tde_cond, rdf_cond;
  logic [1:0] req_q, req_wclr;
  assign tde_cond = !tfrst_q && space_over(int'(tx_cnt), DEPTH, int'(thr_tx));
  assign rdf_cond = !rfrst_q && fill_over(int'(rx_cnt), int'(thr_rx));
  assign req_wclr = wr_fstat ? {~bus_wdata[B_TREQ], ~bus_wdata[B_RREQ]} : 2'b0;

  pcm_sticky_bits #(.N(2)) u_req_flags (
    .clk(clk), .rst_n(rst_n), .wipe(srst_q), .hold({tfrst_q, rfrst_q}),
    .set({tde_cond, rdf_cond}), .wclr(req_wclr), .q(req_q)
  );

  // Outputs
  logic idle;
  assign idle       = (tx_cnt == '0) && (rx_cnt == '0);
  assign tx_req_irq = req_q[1] & tie_q;
  assign rx_req_irq = req_q[0] & rie_q;
  assign err_irq    = |(err_q & err_en);
  assign aclk_en    = aclk_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_ERREN: bus_rdata[B_ERR_LO +: 4] = err_en;
      A_ERRST: begin
        bus_rdata[B_ERR_LO +: 4] = err_q;
        bus_rdata[B_IDLE]        = idle;
      end
      A_FCTL: begin
        bus_rdata[B_ACLK]  = aclk_q;
        bus_rdata[B_SRST]  = srst_q;
        bus_rdata[B_TIE]   = tie_q;
        bus_rdata[B_RIE]   = rie_q;
        bus_rdata[B_TFRST] = tfrst_q;
        bus_rdata[B_RFRST] = rfrst_q;
      end
      A_FSTAT: begin
        bus_rdata[B_TXCNT +: CW] = tx_cnt;
        bus_rdata[B_TREQ]        = req_q[1];
        bus_rdata[B_RXCNT +: CW] = rx_cnt;
        bus_rdata[B_RREQ]        = req_q[0];
      end
      A_THR: begin
        bus_rdata[B_TXTHR +: THR_W] = thr_tx;
        bus_rdata[B_RXTHR +: THR_W] = thr_rx;
      end
      A_RXD:   bus_rdata[WIDTH-1:0] = rx_head;
      default: bus_rdata = '0;
    endcase
  end

  assert_srst_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> !srst_q);
  assert_srst_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (tx_cnt == '0 && rx_cnt == '0 && thr_tx == '0 && err_q == '0));
  assert_tx_hold_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tfrst_q && !srst_q) |=> !err_q[3] || $past(err_q[3]));
endmodule

// File: tb/pcm_fifo_pair_tb.sv
module pcm_fifo_pair_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        tx_pull = 1'b0, rx_push = 1'b0;
  logic [31:0] tx_word, rx_word = '0;
  logic        tx_req_irq, rx_req_irq, err_irq, aclk_en;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pcm_fifo_pair u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_pull(tx_pull), .tx_word(tx_word), .rx_push(rx_push), .rx_word(rx_word),
    .tx_req_irq(tx_req_irq), .rx_req_irq(rx_req_irq), .err_irq(err_irq),
    .aclk_en(aclk_en)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic pull(output logic [31:0] w);
    @(negedge clk); w = tx_word; tx_pull = 1'b1;
    @(negedge clk); tx_pull = 1'b0;
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk); rx_word = w; rx_push = 1'b1;
    @(negedge clk); rx_push = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] e);
    logic [31:0] d;
    rd(a, d);
    check(req, d, e);
  endtask

  // {is_read, addr, data, expected, requirement number}
  localparam int NV = 13;
  localparam logic [71:0] VEC [NV] = '{
    {1'b1, 3'd0, 32'h0, 32'h0000_0000, 4'd1},   // R1 enables clear
    {1'b1, 3'd3, 32'h0, 32'h0001_0000, 4'd1},   // R1 only transmit request up
    {1'b1, 3'd1, 32'h0, 32'h0200_0000, 4'd11},  // R11 idle
    {1'b0, 3'd4, 32'h0000_1F03, 32'h0, 4'd6},
    {1'b1, 3'd4, 32'h0, 32'h0000_1F03, 4'd6},   // R6 thresholds read back
    {1'b0, 3'd5, 32'h0000_00A1, 32'h0, 4'd2},
    {1'b0, 3'd5, 32'h0000_00A2, 32'h0, 4'd2},
    {1'b1, 3'd3, 32'h0, 32'h0201_0000, 4'd6},   // R6 count 2, flag sticky
    {1'b0, 3'd3, 32'h0, 32'h0, 4'd6},
    {1'b1, 3'd3, 32'h0, 32'h0200_0000, 4'd6},   // R6 cleared by zero
    {1'b1, 3'd1, 32'h0, 32'h0000_0000, 4'd11},  // R11 not idle
    {1'b0, 3'd0, 32'hFFFF_FFFF, 32'h0, 4'd8},
    {1'b1, 3'd0, 32'h0, 32'h3C00_0000, 4'd8}    // R8 only 29:26 writable
  };

  initial begin
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irqs", {28'h0, tx_req_irq, rx_req_irq, err_irq, aclk_en}, 32'h0);
    check("R1 tx_word", tx_word, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][71]) begin
        rd(VEC[i][70:68], w);
        check($sformatf("table[%0d] R%0d", i, VEC[i][3:0]), w, VEC[i][35:4]);
      end else begin
        wr(VEC[i][70:68], VEC[i][67:36]);
      end
    end

    wr(3'd2, 32'h8000_000C);
    rd_chk("R11 fctl", 3'd2, 32'h8000_000C);
    check("R11 aclk_en", {31'h0, aclk_en}, 32'h1);

    // R2 order
    pull(w); check("R2 first", w, 32'hA1);
    pull(w); check("R2 second", w, 32'hA2);

    // R3 transmit overflow
    for (int i = 0; i < 33; i++) wr(3'd5, 32'hD000_0000 + i);
    @(negedge clk);
    rd_chk("R3 full count", 3'd3, 32'h2001_0000);
    rd_chk("R3 tx ovf flag", 3'd1, 32'h1000_0000);
    check("R8 err_irq", {31'h0, err_irq}, 32'h1);
    check("R8 tx_req_irq", {31'h0, tx_req_irq}, 32'h1);
    wr(3'd3, 32'h0);
    @(negedge clk);
    rd_chk("R6 clear when full", 3'd3, 32'h2000_0000);
    check("R8 tx_req_irq low", {31'h0, tx_req_irq}, 32'h0);
    for (int i = 0; i < 32; i++) begin
      pull(w); check($sformatf("R2 tx word %0d", i), w, 32'hD000_0000 + i);
    end
    pull(w); check("R4 tx udf data", w, 32'h0);
    @(negedge clk);
    rd_chk("R4 tx udf flag", 3'd1, 32'h3200_0000);

    // R5 sticky error clear
    wr(3'd1, 32'hFFFF_FFFF);
    rd_chk("R5 ones keep", 3'd1, 32'h3200_0000);
    wr(3'd1, 32'hEFFF_FFFF);
    rd_chk("R5 single clear", 3'd1, 32'h2200_0000);
    wr(3'd1, 32'h0);
    rd_chk("R5 all clear", 3'd1, 32'h0200_0000);
    check("R8 err_irq low", {31'h0, err_irq}, 32'h0);

    // R7 receive threshold 3
    for (int i = 0; i < 3; i++) push(32'hC000_0000 + i);
    @(negedge clk);
    rd_chk("R7 at threshold", 3'd3, 32'h0001_0300);
    check("R7 rx irq low", {31'h0, rx_req_irq}, 32'h0);
    push(32'hC000_0003);
    @(negedge clk);
    rd_chk("R7 above threshold", 3'd3, 32'h0001_0401);
    check("R8 rx_req_irq", {31'h0, rx_req_irq}, 32'h1);
    for (int i = 4; i < 33; i++) push(32'hC000_0000 + i);
    @(negedge clk);
    rd_chk("R4 rx ovf flag", 3'd1, 32'h0400_0000);
    check("R8 err_irq rx", {31'h0, err_irq}, 32'h1);
    for (int i = 0; i < 32; i++) rd_chk($sformatf("R2 rx word %0d", i), 3'd6, 32'hC000_0000 + i);
    rd_chk("R3 rx udf data", 3'd6, 32'h0);
    rd_chk("R3 rx udf flag", 3'd1, 32'h0E00_0000);
    wr(3'd1, 32'h0);
    wr(3'd3, 32'h0);
    rd_chk("R7 cleared", 3'd3, 32'h0001_0000);

    // R9 transmit FIFO held, receive runs
    wr(3'd2, 32'h8000_000E);
    wr(3'd5, 32'h55);
    pull(w);
    push(32'h77);
    @(negedge clk);
    rd_chk("R9 held status", 3'd3, 32'h0000_0100);
    check("R9 tx irq off", {31'h0, tx_req_irq}, 32'h0);
    rd_chk("R9 no errors", 3'd1, 32'h0);
    wr(3'd2, 32'h8000_000C);
    @(negedge clk);
    rd_chk("R9 released", 3'd3, 32'h0001_0100);
    rd_chk("R9 rx kept data", 3'd6, 32'h77);

    // R10 soft reset
    wr(3'd5, 32'h99);
    wr(3'd4, 32'h0505);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = 32'h0001_0000;
    @(negedge clk); bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = 3'd2; #1 w = bus_rdata;
    check("R10 bit reads one", w, 32'h0001_0000);
    @(negedge clk); bus_rd = 1'b0;
    rd_chk("R10 self clears", 3'd2, 32'h0);
    rd_chk("R10 status back", 3'd3, 32'h0001_0000);
    rd_chk("R10 thr back", 3'd4, 32'h0);
    rd_chk("R10 enables back", 3'd0, 32'h0);
    rd_chk("R10 idle", 3'd1, 32'h0200_0000);
    check("R10 aclk_en", {31'h0, aclk_en}, 32'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule